// File: doc/BRIEF.md
# Address-Space Identifier Allocator

This block issues 8-bit address-space identifiers (ASIDs) to newly created processes. It keeps one bit of usage state per identifier. On each accepted request it returns the lowest-numbered identifier that is still free and marks that identifier as used. Identifier 0 is reserved and is never handed out.

Once identifiers 1 through 255 are all in use, the next accepted request issues no grant. Instead the block sends a single-cycle request for a global TLB invalidation. It then stops taking requests until the invalidation is acknowledged. On the acknowledge it clears the usage state, keeping only the reserved bit set, and answers the stalled request with identifier 1. From then on allocation proceeds in ascending order as before.

The requester presents `req_i`. A request is taken in any cycle in which `req_i` and `ready_o` are both high. The requester keeps `req_i` asserted until the request is taken.

Top module: `asid_alloc`

## Requirements
- R1: After reset, `ready_o` is 1, and `grant_valid_o` and `flush_req_o` are 0.
- R2: Each grant carries the lowest-numbered free identifier. The first grant after reset is 1, and the grants that follow rise by one.
- R3: A request taken at a clock edge raises `grant_valid_o` for exactly one cycle after that edge. Requests held on consecutive cycles are taken one per cycle.
- R4: Identifier 0 is never granted.
- R5: Between two invalidations, no identifier is granted more than once.
- R6: When identifiers 1 to 255 are all used, the next request that is taken produces no grant. It raises `flush_req_o` for exactly one cycle and drives `ready_o` to 0.
- R7: While the block waits for the invalidation acknowledge, `ready_o` stays 0, `req_i` has no effect, and no grant is issued.
- R8: When `flush_done_i` is sampled high during the wait, the stalled request is granted identifier 1 in the next cycle and `ready_o` returns to 1. The next request after that receives identifier 2.
- R9: When `flush_done_i` is sampled high outside the wait, it has no effect: no grant, no flush request, and no change to the allocation sequence.
- R10: A cycle with `req_i` low produces no grant and consumes no identifier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Allocation request, held until taken |
| ready_o | output | 1 | High when a request can be taken this cycle |
| grant_valid_o | output | 1 | One-cycle pulse marking a grant |
| grant_asid_o | output | 8 | Granted identifier, valid together with grant_valid_o |
| flush_req_o | output | 1 | One-cycle pulse requesting a global TLB invalidation |
| flush_done_i | input | 1 | Acknowledge that the invalidation has finished |

## Verification
Every result is registered once:
- A grant appears in the cycle after the edge at which its request was taken.
- The flush pulse appears in the cycle after the edge that took the request which found the pool empty.
- The identifier-1 grant appears in the cycle after the edge at which the acknowledge was sampled.

The bench drives inputs on the falling edge. It samples the outputs on the next falling edge, which falls exactly in the cycle where each result is due. It keeps its own count of the next expected identifier and a per-round record of identifiers already issued. It walks the whole pool twice, once with irregular gaps between requests and once back-to-back, to cover every identifier and both exhaustion paths.

// File: rtl/asid_pkg.sv
package asid_pkg;
  typedef enum logic {
    ST_RUN  = 1'b0,
    ST_WAIT = 1'b1
  } alloc_state_e;
endpackage

// File: rtl/asid_free_find.sv
// Lowest-zero search in two levels: per-group search, then group select.
module asid_free_find #(
  parameter int N     = 256,
  parameter int GROUP = 16
) (
  input  logic [N-1:0]         used_i,
  output logic                 found_o,
  output logic [$clog2(N)-1:0] idx_o
);
  localparam int IDX_W   = $clog2(N);
  localparam int GROUP_W = $clog2(GROUP);
  localparam int GRP_N   = N / GROUP;
  localparam int GSEL_W  = $clog2(GRP_N);

  logic [GRP_N-1:0]   grp_free;
  logic [GROUP_W-1:0] grp_idx [GRP_N];
  logic [GSEL_W-1:0]  sel;

  function automatic logic [GROUP_W-1:0] low_zero(input logic [GROUP-1:0] v);
    logic [GROUP_W-1:0] r;
    r = '0;
    for (int b = GROUP - 1; b >= 0; b--) begin
      if (!v[b]) r = b[GROUP_W-1:0];
    end
    return r;
  endfunction

  for (genvar g = 0; g < GRP_N; g++) begin : g_grp
    assign grp_free[g] = ~&used_i[g*GROUP +: GROUP];
    assign grp_idx[g]  = low_zero(used_i[g*GROUP +: GROUP]);
  end

  always_comb begin
    sel = '0;
    for (int g = GRP_N - 1; g >= 0; g--) begin
      if (grp_free[g]) sel = g[GSEL_W-1:0];
    end
  end

  assign found_o = |grp_free;
  assign idx_o   = IDX_W'({sel, grp_idx[sel]});
endmodule

// File: rtl/asid_bitmap.sv
module asid_bitmap #(
  parameter int N = 256
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clear_i,
  input  logic                 set_i,
  input  logic [$clog2(N)-1:0] set_idx_i,
  output logic [N-1:0]         used_o
);
  // Bit 0 is the reserved identifier: always marked used.
  localparam logic [N-1:0] BASE_MAP = {{(N-1){1'b0}}, 1'b1};

  logic [N-1:0] used_q, used_d;

  always_comb begin
    used_d = clear_i ? BASE_MAP : used_q;
    if (set_i) used_d[set_idx_i] = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) used_q <= BASE_MAP;
    else         used_q <= used_d;
  end

  assign used_o = used_q;

  assert_set_free_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_i && !clear_i) |-> !used_q[set_idx_i]);
  assert_reserved_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |-> (set_idx_i != '0));
endmodule

// File: rtl/asid_ctl.sv
module asid_ctl
  import asid_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic found_i,
  input  logic flush_done_i,
  output logic ready_o,
  output logic grant_fire_o,
  output logic refill_o,
  output logic flush_fire_o
);
  alloc_state_e state_q, state_d;
  logic accept;

  assign ready_o      = (state_q == ST_RUN);
  assign accept       = ready_o && req_i;
  assign flush_fire_o = accept && !found_i;
  assign refill_o     = (state_q == ST_WAIT) && flush_done_i;
  assign grant_fire_o = (accept && found_i) || refill_o;

  always_comb begin
    state_d = state_q;
    if (flush_fire_o) state_d = ST_WAIT;
    else if (refill_o) state_d = ST_RUN;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_RUN;
    else         state_q <= state_d;
  end

  assert_wait_exit_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && flush_done_i) |=> (state_q == ST_RUN));
  assert_wait_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT && !flush_done_i) |=> (state_q == ST_WAIT));
  assert_done_ignored_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && flush_done_i && !req_i) |=> (state_q == ST_RUN));
endmodule

// File: rtl/asid_alloc.sv
module asid_alloc #(
  parameter int ASID_W = 8,
  parameter int GROUP  = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  output logic              ready_o,
  output logic              grant_valid_o,
  output logic [ASID_W-1:0] grant_asid_o,
  output logic              flush_req_o,
  input  logic              flush_done_i
);
  localparam int N = 1 << ASID_W;
  localparam logic [ASID_W-1:0] FIRST_ASID = ASID_W'(1);

  logic [N-1:0]      used;
  logic              found;
  logic [ASID_W-1:0] free_idx, pick_idx;
  logic              grant_fire, refill, flush_fire;

  asid_free_find #(.N(N), .GROUP(GROUP)) i_find (
    .used_i (used),
    .found_o(found),
    .idx_o  (free_idx)
  );

  asid_ctl i_ctl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_i),
    .found_i     (found),
    .flush_done_i(flush_done_i),
    .ready_o     (ready_o),
    .grant_fire_o(grant_fire),
    .refill_o    (refill),
    .flush_fire_o(flush_fire)
  );

  // After a refill the cleared map's lowest free entry is known.
  assign pick_idx = refill ? FIRST_ASID : free_idx;

  asid_bitmap #(.N(N)) i_map (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (refill),
    .set_i    (grant_fire),
    .set_idx_i(pick_idx),
    .used_o   (used)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      grant_valid_o <= 1'b0;
      grant_asid_o  <= '0;
      flush_req_o   <= 1'b0;
    end else begin
      grant_valid_o <= grant_fire;
      flush_req_o   <= flush_fire;
      if (grant_fire) grant_asid_o <= pick_idx;
    end
  end

  assert_no_zero_grant_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> (grant_asid_o != '0));
  assert_grant_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    grant_valid_o |-> ($past(req_i && ready_o) || $past(flush_done_i && !ready_o)));
  assert_flush_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |-> (!grant_valid_o && !ready_o));
  assert_flush_single_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_req_o |=> !flush_req_o);
  assert_wait_silent_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_o |-> !grant_valid_o);
endmodule

// File: tb/test_asid_alloc.sv
module test_asid_alloc;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       req_i = 1'b0;
  logic       flush_done_i = 1'b0;
  logic       ready_o, grant_valid_o, flush_req_o;
  logic [7:0] grant_asid_o;

  int errs = 0;
  int checks = 0;
  bit done_flag = 0;
  bit seen [256];
  int next_id;

  always #2 clk_i = ~clk_i;

  asid_alloc i_asid_alloc (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .ready_o      (ready_o),
    .grant_valid_o(grant_valid_o),
    .grant_asid_o (grant_asid_o),
    .flush_req_o  (flush_req_o),
    .flush_done_i (flush_done_i)
  );

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%0d expected=%0d", rq, act, exp);
    end
  endtask

  task automatic step(input bit r, input bit d);
    req_i = r;
    flush_done_i = d;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_seen();
    for (int i = 0; i < 256; i++) seen[i] = 0;
  endtask

  task automatic expect_grant(input int id);
    chk(grant_valid_o == 1'b1, "R3 grant valid", int'(grant_valid_o), 1);
    chk(int'(grant_asid_o) == id, "R2 grant id", int'(grant_asid_o), id);
    chk(grant_asid_o != 8'd0, "R4 nonzero", int'(grant_asid_o), id);
    chk(!seen[grant_asid_o], "R5 unique", int'(grant_asid_o), id);
    seen[grant_asid_o] = 1;
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    checks++;
    errs++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    finish_run();
  end

  initial begin
    clear_seen();
    repeat (3) @(posedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    // R1
    chk(ready_o == 1'b1, "R1 ready", int'(ready_o), 1);
    chk(grant_valid_o == 1'b0, "R1 grant", int'(grant_valid_o), 0);
    chk(flush_req_o == 1'b0, "R1 flush", int'(flush_req_o), 0);

    step(1, 0);
    expect_grant(1);
    step(0, 0);
    chk(grant_valid_o == 1'b0, "R3 single pulse", int'(grant_valid_o), 0);
    // R9: acknowledge outside the wait is ignored
    step(0, 1);
    chk(grant_valid_o == 1'b0, "R9 no grant", int'(grant_valid_o), 0);
    chk(flush_req_o == 1'b0, "R9 no flush", int'(flush_req_o), 0);
    chk(ready_o == 1'b1, "R9 ready", int'(ready_o), 1);
    step(0, 0);
    chk(grant_valid_o == 1'b0, "R10 idle", int'(grant_valid_o), 0);

    // Round 1: irregular gaps
    next_id = 2;
    for (int i = 0; next_id <= 255 && i < 1000; i++) begin
      bit r;
      r = (i % 5) != 3;
      step(r, 0);
      if (r) begin
        expect_grant(next_id);
        next_id++;
      end else begin
        chk(grant_valid_o == 1'b0, "R10 gap", int'(grant_valid_o), 0);
      end
    end

    // R6: exhaustion
    step(1, 0);
    chk(flush_req_o == 1'b1, "R6 flush", int'(flush_req_o), 1);
    chk(grant_valid_o == 1'b0, "R6 no grant", int'(grant_valid_o), 0);
    chk(ready_o == 1'b0, "R6 ready low", int'(ready_o), 0);
    for (int k = 0; k < 4; k++) begin
      step(1, 0);
      chk(flush_req_o == 1'b0, "R6 pulse ends", int'(flush_req_o), 0);
      chk(grant_valid_o == 1'b0, "R7 stalled", int'(grant_valid_o), 0);
      chk(ready_o == 1'b0, "R7 ready low", int'(ready_o), 0);
    end
    clear_seen();
    step(0, 1);
    expect_grant(1);
    chk(ready_o == 1'b1, "R8 ready back", int'(ready_o), 1);
    step(1, 0);
    expect_grant(2);

    // Round 2: back-to-back
    for (int id = 3; id <= 255; id++) begin
      step(1, 0);
      expect_grant(id);
    end
    step(1, 0);
    chk(flush_req_o == 1'b1, "R6 flush round 2", int'(flush_req_o), 1);
    chk(grant_valid_o == 1'b0, "R6 no grant round 2", int'(grant_valid_o), 0);
    step(0, 0);
    chk(ready_o == 1'b0, "R7 wait round 2", int'(ready_o), 0);
    clear_seen();
    step(0, 1);
    expect_grant(1);
    step(0, 0);
    chk(grant_valid_o == 1'b0, "R10 final idle", int'(grant_valid_o), 0);
    finish_run();
  end
endmodule